// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

This block gives a CPU three 8-bit general-purpose ports, called A, B and C, through a small register interface on an 8-bit data bus. Port C is handled as two 4-bit halves. Each half has its own direction. A two-bit register select picks port A, port B, port C or a write-only control register. The block is accessed only while the chip select is high.

The control register accepts two kinds of command, and bit 7 tells them apart. A configuration word sets the directions of port A, port B, upper C and lower C, all in plain level-sensitive I/O. A single-bit command sets or clears one port C output latch. Only plain I/O is built. A configuration word that asks for a strobed or bidirectional mode is refused, and it raises a sticky flag.

Each port pin has an output value and an output-enable. A port that is an output drives its latch with the enable high. A port that is an input has the enable low, and reads of it return the live pin values.

Top module: `tri_port_pio`

## Requirements
- R1: The register select maps 0 to port A, 1 to port B, 2 to port C and 3 to the control register. Writes take effect at the rising clock edge. Read data is combinational.
- R2: A read at select 3 returns 0x00. When no read is selected (sel and rd not both high), read data is 0x00.
- R3: After reset (rst high), every output-enable is 0, every output latch is 0x00 and the unsupported flag is 0. All four port sections are inputs.
- R4: A control write with bit 7 = 1 is a configuration word. Bit 4 sets the port A direction, bit 3 upper C (pins 7:4), bit 1 port B and bit 0 lower C (pins 3:0). A bit value of 1 means input and 0 means output. For example, 0x82 makes A, upper C and lower C outputs and B an input.
- R5: An accepted configuration word clears the A, B and C output latches to 0x00.
- R6: A control write with bit 7 = 0 changes exactly one port C latch bit. Bits 3:1 give the bit index and bit 0 gives the new value. Bits 6:4 have no effect.
- R7: A write to port A, B or C loads the whole byte into that port's latch. The pin outputs always show the latch. The enables are 0xFF for an output port and 0x00 for an input port, and each half of port C is handled separately.
- R8: A read of a port or half that is an output returns its latch. A read of a port or half that is an input returns its pins. For port C the two halves are chosen independently.
- R9: A configuration word with bits 6:5 not 00 or with bit 2 = 1 sets the unsupported flag. That word leaves the directions and latches unchanged. The flag stays set until reset.
- R10: A write with sel low has no effect on latches, directions or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C output enables |
| unsupported | output | 1 | Sticky flag: a refused mode was requested |

## Verification
Two things can happen in the same cycle. A port C read can be combined with a port C write, and a port C read can meet halves that have different directions. The bench raises read and write together at select 2 and samples the read data before the edge, where it must still show the old latch. After the edge, the new byte must be visible. Port C reads are also made under random split directions and random pins. Each half is judged on its own against a bench function: latch for an output half, pins for an input half.

// File: rtl/tri_port_pio.sv
module tri_port_pio #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic          unsupported
);
  localparam int HW = PW / 2;
  localparam int SW = $clog2(PW);

  logic [PW-1:0] pa_q, pb_q, pc_q;
  logic a_in, b_in, cu_in, cl_in, unsup_q;

  wire do_wr    = sel && wr;
  wire ctl_wr   = do_wr && addr == 2'd3;
  wire mode_wr  = ctl_wr && wdata[7];
  wire bit_wr   = ctl_wr && !wdata[7];
  wire mode_ok  = wdata[6:5] == 2'b00 && !wdata[2];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pa_q <= '0; pb_q <= '0; pc_q <= '0;
      a_in <= 1'b1; b_in <= 1'b1; cu_in <= 1'b1; cl_in <= 1'b1;
      unsup_q <= 1'b0;
    end else if (do_wr) begin
      case (addr)
        2'd0: pa_q <= wdata;
        2'd1: pb_q <= wdata;
        2'd2: pc_q <= wdata;
        default: begin
          if (mode_wr) begin
            if (mode_ok) begin
              a_in  <= wdata[4];
              cu_in <= wdata[3];
              b_in  <= wdata[1];
              cl_in <= wdata[0];
              pa_q  <= '0; pb_q <= '0; pc_q <= '0;
            end else begin
              unsup_q <= 1'b1;
            end
          end else begin
            pc_q[wdata[SW:1]] <= wdata[0];
          end
        end
      endcase
    end
  end

  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign pa_oe  = {PW{!a_in}};
  assign pb_oe  = {PW{!b_in}};
  assign pc_oe  = {{HW{!cu_in}}, {HW{!cl_in}}};
  assign unsupported = unsup_q;

  always_comb begin
    rdata = '0;
    if (sel && rd) begin
      case (addr)
        2'd0: rdata = a_in ? pa_in : pa_q;
        2'd1: rdata = b_in ? pb_in : pb_q;
        2'd2: rdata = {cu_in ? pc_in[PW-1:HW] : pc_q[PW-1:HW],
                       cl_in ? pc_in[HW-1:0]  : pc_q[HW-1:0]};
        default: rdata = '0;
      endcase
    end
  end

  a_r3_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pc_out == '0 && !unsupported));

  a_r2_ctrl_read_zero: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && addr == 2'd3) |-> rdata == '0);

  a_r6_one_bit_changes: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> $countones(pc_out ^ $past(pc_out)) <= 1);

  a_r6_ports_ab_untouched: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_oe)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    unsupported |=> unsupported);

  a_r9_refused_keeps_config: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !mode_ok) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out)));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !do_wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe) && $stable(unsupported)));

  a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_ok) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));
endmodule

// File: tb/tri_port_pio_test.sv
module tri_port_pio_test;
  logic clk = 0, rst = 1, sel = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic unsupported;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // bench model: direction 1 = input
  bit m_a, m_b, m_cu, m_cl, m_unsup;
  logic [7:0] m_la, m_lb, m_lc;

  always #5 clk = ~clk;

  tri_port_pio uut (.clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe), .unsupported(unsupported));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_a ? pa_in : m_la;
      2'd1: return m_b ? pb_in : m_lb;
      2'd2: return {m_cu ? pc_in[7:4] : m_lc[7:4], m_cl ? pc_in[3:0] : m_lc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_pc_oe();
    return {{4{!m_cu}}, {4{!m_cl}}};
  endfunction

  task automatic model_reset();
    m_a = 1; m_b = 1; m_cu = 1; m_cl = 1; m_unsup = 0;
    m_la = 0; m_lb = 0; m_lc = 0;
  endtask

  task automatic model_write(logic [1:0] a, logic [7:0] d);
    case (a)
      2'd0: m_la = d;
      2'd1: m_lb = d;
      2'd2: m_lc = d;
      default: begin
        if (d[7]) begin
          if (d[6:5] == 0 && !d[2]) begin
            m_a = d[4]; m_cu = d[3]; m_b = d[1]; m_cl = d[0];
            m_la = 0; m_lb = 0; m_lc = 0;
          end else m_unsup = 1;
        end else m_lc[d[3:1]] = d[0];
      end
    endcase
  endtask

  task automatic do_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
    model_write(a, d);
  endtask

  task automatic check_outputs(string req);
    check({req, " pa_out"}, pa_out, m_la);
    check({req, " pb_out"}, pb_out, m_lb);
    check({req, " pc_out"}, pc_out, m_lc);
    check({req, " pa_oe"}, pa_oe, {8{!m_a}});
    check({req, " pb_oe"}, pb_oe, {8{!m_b}});
    check({req, " pc_oe"}, pc_oe, exp_pc_oe());
    check({req, " flag"}, {7'd0, unsupported}, {7'd0, m_unsup});
  endtask

  task automatic check_read(string req, logic [1:0] a);
    sel = 1; rd = 1; addr = a;
    #1;
    check(req, rdata, exp_read(a));
    sel = 0; rd = 0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) @(negedge clk);
    check_outputs("R3 reset");
    rst = 0;
    @(negedge clk);
    check_outputs("R3 after release");
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    check_read("R8 input read A", 2'd0);
    check_read("R8 input read C", 2'd2);
    check_read("R2 control read", 2'd3);
    sel = 0; rd = 1; addr = 2'd0; #1;
    check("R2 no select read", rdata, 8'h00);
    rd = 0;

    // R4 configuration example
    do_write(2'd0, 8'h11);
    do_write(2'd3, 8'h82);
    check_outputs("R4 word 82h");
    check("R4 A out", pa_oe, 8'hFF);
    check("R4 B in", pb_oe, 8'h00);
    check("R5 cleared A", pa_out, 8'h00);
    do_write(2'd0, 8'hA5);
    check("R7 A latch", pa_out, 8'hA5);
    check_read("R8 output read A", 2'd0);
    check_read("R1 read B pins", 2'd1);
    check_read("R2 control read", 2'd3);

    // R6 single bit with junk in bits 6:4
    do_write(2'd2, 8'h00);
    do_write(2'd3, 8'h77);   // bit 3 set, bits 6:4 = 111
    check("R6 set bit3", pc_out, 8'h08);
    do_write(2'd3, 8'h0F);   // bit 7 set
    check("R6 set bit7", pc_out, 8'h88);
    do_write(2'd3, 8'h76);   // bit 3 clear
    check("R6 clear bit3", pc_out, 8'h80);
    check_outputs("R6 others intact");

    // R10 deselected write
    @(negedge clk); sel = 0; wr = 1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk); wr = 0;
    check("R10 ignored A", pa_out, 8'hA5);
    @(negedge clk); sel = 0; wr = 1; addr = 2'd3; wdata = 8'h80;
    @(negedge clk); wr = 0;
    check_outputs("R10 ignored ctl");

    // same-cycle read and write of port C
    @(negedge clk);
    sel = 1; rd = 1; wr = 1; addr = 2'd2; wdata = 8'h3C;
    #1;
    check("R1 read before edge", rdata, exp_read(2'd2));
    @(negedge clk);
    model_write(2'd2, 8'h3C);
    check("R7 read after edge", rdata, exp_read(2'd2));
    sel = 0; rd = 0; wr = 0;

    // split nibbles
    do_write(2'd3, 8'h89);   // A out, CU in, B out, CL in
    do_write(2'd2, 8'hE7);
    pc_in = 8'h5A;
    check_read("R8 split C read", 2'd2);
    do_write(2'd3, 8'h81);   // CU out, CL in
    do_write(2'd2, 8'hE7);
    check_read("R8 split C read 2", 2'd2);
    check("R7 pc_oe split", pc_oe, 8'hF0);

    // R9 refused modes
    do_write(2'd3, 8'hA0);
    check_outputs("R9 mode1 refused");
    check("R9 flag", {7'd0, unsupported}, 8'h01);
    do_write(2'd3, 8'h84);
    check_outputs("R9 B mode refused");
    do_write(2'd3, 8'h9B);
    check_outputs("R9 flag sticky");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      d = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if (op < 4) do_write(2'(op), d);
      else if (op < 6) do_write(2'd3, {1'b0, d[6:0]});
      else if (op < 8) do_write(2'd3, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]});
      else if (op == 8) do_write(2'd3, {1'b1, d[6:0]});
      else begin
        @(negedge clk); sel = 0; wr = 1; addr = 2'($urandom); wdata = d;
        @(negedge clk); wr = 0;
      end
      check_outputs("R7 random");
      check_read("R8 random", 2'($urandom));
    end

    // reset again mid-run
    @(negedge clk); rst = 1; model_reset();
    @(negedge clk);
    check_outputs("R3 second reset");
    rst = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule